// File: doc/BRIEF.md
# Reference PLL Bring-Up Sequencer

This block is a hardware state machine that powers up the reference PLL of a serial link. A single start strobe launches a fixed, ordered sequence. First the software override controls are taken. Then the trim and divider fields are loaded, and the PLL is walked out of its power-down states. The sequence then runs three status handshakes against the analog macro: a calibration handshake, a lock wait and a resistor-calibration handshake. When all three have completed, control of the PLL is handed to the autonomous hardware sequencer.

Each wait is bounded by its own timeout. The limit is set in clock cycles, computed from the clock frequency and a limit in milliseconds. When a wait times out, the sequence stops and reports an error code that names the phase that failed. On error, and also on success, every control output is frozen at its last value until the next start. The analog PLL is outside this block and connects through the three status inputs.

Top module: `pll_bringup_seq`

## Requirements
- R1: After reset the outputs hold their power-down values: trim, divider and select fields are 0, except refclk_sel = 4'h5 and fb_mdiv = 2'd1. The following are 1: iddq, rst_sw_ctrl and clk_sw_ctrl. sleep_lvl = 2'b11. Every other control is 0, and seq_done, seq_err and seq_err_code are 0.
- R2: When a start is accepted, the three override bits (pwr_ovrd, cal_ovrd, rcal_ovrd) rise together one cycle after the start edge. This happens before iddq clears.
- R3: The load step sets cal_trim = 24'h000136, dco_trim = 8'h2A, txref_sel = 2, txref_en = 1, fb_ndiv = 25, fb_mdiv = 0 and refclk_sel = 0. All of these fields hold those values through to completion.
- R4: Four power-up steps occur in consecutive cycles, in this order: iddq falls, sleep_lvl becomes 0, refbuf_en rises, cal_en rises.
- R5: cal_en falls only after cal_done has been seen high. pll_en rises only after cal_done has then been seen low, with cal_en already low.
- R6: rcal_clk_en and rcal_en rise together, and only after lock_det has been seen high while pll_en is set.
- R7: rcal_en falls only after rcal_done has been seen high. rcal_clk_en falls only after rcal_done has then been seen low.
- R8: The hand-off step clears rst_sw_ctrl and clk_sw_ctrl and sets lockdet_use and idle_iddq_ctrl. The overrides are then released one per cycle, in the order pwr_ovrd, cal_ovrd, rcal_ovrd. In the next cycle hw_seq_en and seq_done rise together.
- R9: Each wait lasts at most TMO = (CLK_HZ/1000)*TIMEOUT_MS cycles. When a wait expires, seq_err rises exactly TMO cycles after the control edge that began the wait. seq_err_code then names the phase: 1 = calibration done never set, 2 = calibration done never cleared, 3 = no lock, 4 = resistor-calibration done never set, 5 = resistor-calibration done never cleared.
- R10: While seq_done or seq_err is high and no start arrives, every control output and seq_err_code stays unchanged.
- R11: A start strobe that arrives while the sequence is running is ignored: the run completes with the same total cycle count.
- R12: seq_done is a level that stays high until the next start. A start in the idle, done or error state clears seq_done and seq_err and restores the R1 values at the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, one cycle |
| cal_done | input | 1 | PLL calibration done status |
| lock_det | input | 1 | PLL lock-detect status |
| rcal_done | input | 1 | Resistor-calibration done status |
| cal_trim | output | 24 | Calibration control field |
| dco_trim | output | 8 | Oscillator control field |
| txref_sel | output | 2 | TX clock reference select |
| txref_en | output | 1 | TX clock reference enable |
| refclk_sel | output | 4 | Reference clock select |
| refbuf_en | output | 1 | Reference clock buffer enable |
| fb_ndiv | output | 8 | Feedback N divider |
| fb_mdiv | output | 2 | Input M divider |
| pwr_ovrd | output | 1 | Software power override |
| cal_ovrd | output | 1 | Software calibration override |
| rcal_ovrd | output | 1 | Software resistor-calibration override |
| iddq | output | 1 | PLL quiescent power-down |
| sleep_lvl | output | 2 | PLL sleep field |
| cal_en | output | 1 | Calibration enable |
| pll_en | output | 1 | PLL enable |
| rcal_clk_en | output | 1 | Resistor-calibration clock enable |
| rcal_en | output | 1 | Resistor-calibration enable |
| rst_sw_ctrl | output | 1 | PLL reset under software control |
| clk_sw_ctrl | output | 1 | PLL clock enable under software control |
| lockdet_use | output | 1 | Hardware uses lock detect |
| idle_iddq_ctrl | output | 1 | Hardware may enter IDDQ when idle |
| hw_seq_en | output | 1 | Autonomous hardware sequencer enable |
| seq_done | output | 1 | Sequence completed (level) |
| seq_err | output | 1 | Sequence stopped on timeout |
| seq_err_code | output | 3 | Failed wait phase, 0 when none |

## Verification
The bench builds the block with CLK_HZ = 100000 and TIMEOUT_MS = 1, which makes every wait limit 100 cycles instead of tens of millions. With that limit, all five timeout phases can be forced by a PLL responder that withholds one status edge. The exact expiry distance can then be measured in cycles, and a whole run of recovery, restart and mid-run start cases fits in a few thousand cycles.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

    localparam int CAL_W  = 24;
    localparam int DCO_W  = 8;
    localparam int NDIV_W = 8;
    localparam int MDIV_W = 2;
    localparam int RSEL_W = 4;
    localparam int TSEL_W = 2;
    localparam int SLP_W  = 2;

    localparam logic [CAL_W-1:0]  CAL_TRIM_VAL = CAL_W'(24'h000136);
    localparam logic [DCO_W-1:0]  DCO_TRIM_VAL = DCO_W'(8'h2A);
    localparam logic [TSEL_W-1:0] TXREF_VAL    = TSEL_W'(2);
    localparam logic [NDIV_W-1:0] NDIV_VAL     = NDIV_W'(25);
    localparam logic [MDIV_W-1:0] MDIV_VAL     = '0;

    typedef enum logic [4:0] {
        ST_IDLE, ST_OVRD, ST_LOAD, ST_IDDQ, ST_SLEEP, ST_REFBUF, ST_CALEN,
        ST_W_CALHI, ST_CALOFF, ST_W_CALLO, ST_PLLEN, ST_W_LOCK, ST_RCALON,
        ST_W_RCALHI, ST_RCALOFF, ST_W_RCALLO, ST_RCLKOFF, ST_HANDOFF,
        ST_REL_PWR, ST_REL_CAL, ST_REL_RCAL, ST_HWSEQ, ST_DONE, ST_FAIL
    } seq_state_e;

    typedef enum logic [2:0] {
        EC_NONE     = 3'd0,
        EC_CAL_SET  = 3'd1,
        EC_CAL_CLR  = 3'd2,
        EC_LOCK     = 3'd3,
        EC_RCAL_SET = 3'd4,
        EC_RCAL_CLR = 3'd5
    } err_code_e;

    typedef struct packed {
        logic [CAL_W-1:0]  cal_trim;
        logic [DCO_W-1:0]  dco_trim;
        logic [TSEL_W-1:0] txref_sel;
        logic              txref_en;
        logic [RSEL_W-1:0] refclk_sel;
        logic              refbuf_en;
        logic [NDIV_W-1:0] fb_ndiv;
        logic [MDIV_W-1:0] fb_mdiv;
        logic              pwr_ovrd;
        logic              cal_ovrd;
        logic              rcal_ovrd;
        logic              iddq;
        logic [SLP_W-1:0]  sleep_lvl;
        logic              cal_en;
        logic              pll_en;
        logic              rcal_clk_en;
        logic              rcal_en;
        logic              rst_sw_ctrl;
        logic              clk_sw_ctrl;
        logic              lockdet_use;
        logic              idle_iddq_ctrl;
        logic              hw_seq_en;
    } pll_ctl_t;

    function automatic pll_ctl_t ctl_default();
        pll_ctl_t c;
        c = '0;
        c.refclk_sel  = RSEL_W'(4'h5);
        c.fb_mdiv     = MDIV_W'(1);
        c.iddq        = 1'b1;
        c.sleep_lvl   = '1;
        c.rst_sw_ctrl = 1'b1;
        c.clk_sw_ctrl = 1'b1;
        return c;
    endfunction

    function automatic logic is_wait(seq_state_e s);
        return (s == ST_W_CALHI) || (s == ST_W_CALLO) || (s == ST_W_LOCK) ||
               (s == ST_W_RCALHI) || (s == ST_W_RCALLO);
    endfunction

    function automatic err_code_e wait_code(seq_state_e s);
        case (s)
            ST_W_CALHI:  return EC_CAL_SET;
            ST_W_CALLO:  return EC_CAL_CLR;
            ST_W_LOCK:   return EC_LOCK;
            ST_W_RCALHI: return EC_RCAL_SET;
            ST_W_RCALLO: return EC_RCAL_CLR;
            default:     return EC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pllseq_timer.sv
module pllseq_timer #(
    parameter int unsigned CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int unsigned W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [W-1:0] LAST = W'(CYC - 1);

    logic [W-1:0] cnt;

    assign expired = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + W'(1);
        end
    end
endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
    import pllseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       cal_done,
    input  logic       lock_det,
    input  logic       rcal_done,
    input  logic       expired,
    output seq_state_e state,
    output logic       restart,
    output logic       tmr_run,
    output logic       done,
    output logic       err,
    output err_code_e  code
);
    seq_state_e nxt;
    logic       met;
    logic       parked;

    assign parked  = (state == ST_IDLE) || (state == ST_DONE) || (state == ST_FAIL);
    assign restart = start && parked;
    assign tmr_run = is_wait(state);

    always_comb begin
        case (state)
            ST_W_CALHI:  met = cal_done;
            ST_W_CALLO:  met = !cal_done;
            ST_W_LOCK:   met = lock_det;
            ST_W_RCALHI: met = rcal_done;
            ST_W_RCALLO: met = !rcal_done;
            default:     met = 1'b0;
        endcase
    end

    always_comb begin
        nxt = state;
        if (restart) begin
            nxt = ST_OVRD;
        end else if (is_wait(state)) begin
            if (met)          nxt = seq_state_e'(state + 5'd1);
            else if (expired) nxt = ST_FAIL;
        end else if (!parked) begin
            nxt = seq_state_e'(state + 5'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            err   <= 1'b0;
            code  <= EC_NONE;
        end else begin
            state <= nxt;
            if (restart) begin
                done <= 1'b0;
                err  <= 1'b0;
                code <= EC_NONE;
            end else if (state == ST_HWSEQ) begin
                done <= 1'b1;
            end else if (is_wait(state) && !met && expired) begin
                err  <= 1'b1;
                code <= wait_code(state);
            end
        end
    end
endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
    import pllseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  seq_state_e state,
    output pll_ctl_t   ctl
);
    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ctl <= ctl_default();
        end else begin
            case (state)
                ST_OVRD: begin
                    ctl.pwr_ovrd  <= 1'b1;
                    ctl.cal_ovrd  <= 1'b1;
                    ctl.rcal_ovrd <= 1'b1;
                end
                ST_LOAD: begin
                    ctl.cal_trim   <= CAL_TRIM_VAL;
                    ctl.dco_trim   <= DCO_TRIM_VAL;
                    ctl.txref_sel  <= TXREF_VAL;
                    ctl.txref_en   <= 1'b1;
                    ctl.refclk_sel <= '0;
                    ctl.fb_ndiv    <= NDIV_VAL;
                    ctl.fb_mdiv    <= MDIV_VAL;
                end
                ST_IDDQ:    ctl.iddq      <= 1'b0;
                ST_SLEEP:   ctl.sleep_lvl <= '0;
                ST_REFBUF:  ctl.refbuf_en <= 1'b1;
                ST_CALEN:   ctl.cal_en    <= 1'b1;
                ST_CALOFF:  ctl.cal_en    <= 1'b0;
                ST_PLLEN:   ctl.pll_en    <= 1'b1;
                ST_RCALON: begin
                    ctl.rcal_clk_en <= 1'b1;
                    ctl.rcal_en     <= 1'b1;
                end
                ST_RCALOFF: ctl.rcal_en     <= 1'b0;
                ST_RCLKOFF: ctl.rcal_clk_en <= 1'b0;
                ST_HANDOFF: begin
                    ctl.rst_sw_ctrl    <= 1'b0;
                    ctl.clk_sw_ctrl    <= 1'b0;
                    ctl.lockdet_use    <= 1'b1;
                    ctl.idle_iddq_ctrl <= 1'b1;
                end
                ST_REL_PWR:  ctl.pwr_ovrd  <= 1'b0;
                ST_REL_CAL:  ctl.cal_ovrd  <= 1'b0;
                ST_REL_RCAL: ctl.rcal_ovrd <= 1'b0;
                ST_HWSEQ:    ctl.hw_seq_en <= 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
    import pllseq_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned TIMEOUT_MS = 250
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        cal_done,
    input  logic        lock_det,
    input  logic        rcal_done,
    output logic [23:0] cal_trim,
    output logic [7:0]  dco_trim,
    output logic [1:0]  txref_sel,
    output logic        txref_en,
    output logic [3:0]  refclk_sel,
    output logic        refbuf_en,
    output logic [7:0]  fb_ndiv,
    output logic [1:0]  fb_mdiv,
    output logic        pwr_ovrd,
    output logic        cal_ovrd,
    output logic        rcal_ovrd,
    output logic        iddq,
    output logic [1:0]  sleep_lvl,
    output logic        cal_en,
    output logic        pll_en,
    output logic        rcal_clk_en,
    output logic        rcal_en,
    output logic        rst_sw_ctrl,
    output logic        clk_sw_ctrl,
    output logic        lockdet_use,
    output logic        idle_iddq_ctrl,
    output logic        hw_seq_en,
    output logic        seq_done,
    output logic        seq_err,
    output logic [2:0]  seq_err_code
);
    localparam int unsigned TMO_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;

    seq_state_e state;
    err_code_e  code;
    pll_ctl_t   ctl;
    logic       restart;
    logic       tmr_run;
    logic       expired;

    pllseq_timer #(.CYC(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (tmr_run),
        .expired (expired)
    );

    pllseq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cal_done  (cal_done),
        .lock_det  (lock_det),
        .rcal_done (rcal_done),
        .expired   (expired),
        .state     (state),
        .restart   (restart),
        .tmr_run   (tmr_run),
        .done      (seq_done),
        .err       (seq_err),
        .code      (code)
    );

    pllseq_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .state   (state),
        .ctl     (ctl)
    );

    assign seq_err_code   = code;
    assign cal_trim       = ctl.cal_trim;
    assign dco_trim       = ctl.dco_trim;
    assign txref_sel      = ctl.txref_sel;
    assign txref_en       = ctl.txref_en;
    assign refclk_sel     = ctl.refclk_sel;
    assign refbuf_en      = ctl.refbuf_en;
    assign fb_ndiv        = ctl.fb_ndiv;
    assign fb_mdiv        = ctl.fb_mdiv;
    assign pwr_ovrd       = ctl.pwr_ovrd;
    assign cal_ovrd       = ctl.cal_ovrd;
    assign rcal_ovrd      = ctl.rcal_ovrd;
    assign iddq           = ctl.iddq;
    assign sleep_lvl      = ctl.sleep_lvl;
    assign cal_en         = ctl.cal_en;
    assign pll_en         = ctl.pll_en;
    assign rcal_clk_en    = ctl.rcal_clk_en;
    assign rcal_en        = ctl.rcal_en;
    assign rst_sw_ctrl    = ctl.rst_sw_ctrl;
    assign clk_sw_ctrl    = ctl.clk_sw_ctrl;
    assign lockdet_use    = ctl.lockdet_use;
    assign idle_iddq_ctrl = ctl.idle_iddq_ctrl;
    assign hw_seq_en      = ctl.hw_seq_en;
endmodule

// File: rtl/pll_bringup_seq_chk.sv
module pll_bringup_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       cal_done,
    input logic       lock_det,
    input logic       rcal_done,
    input logic [3:0] refclk_sel,
    input logic       refbuf_en,
    input logic       pwr_ovrd,
    input logic       cal_ovrd,
    input logic       rcal_ovrd,
    input logic       iddq,
    input logic [1:0] sleep_lvl,
    input logic       cal_en,
    input logic       pll_en,
    input logic       rcal_clk_en,
    input logic       rcal_en,
    input logic       lockdet_use,
    input logic       hw_seq_en,
    input logic       seq_done,
    input logic       seq_err,
    input logic [2:0] seq_err_code
);
    logic [19:0] watch;
    assign watch = {refclk_sel, refbuf_en, pwr_ovrd, cal_ovrd, rcal_ovrd, iddq,
                    sleep_lvl, cal_en, pll_en, rcal_clk_en, rcal_en, lockdet_use,
                    hw_seq_en, seq_err_code};

    AST_OVRD_BEFORE_PWRUP: assert property (@(posedge clk) disable iff (rst)
        $fell(iddq) |-> (pwr_ovrd && cal_ovrd && rcal_ovrd)); // R2
    AST_CALEN_PREREQ: assert property (@(posedge clk) disable iff (rst)
        $rose(cal_en) |-> (!iddq && sleep_lvl == 2'b00 && refbuf_en)); // R4
    AST_CALEN_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(cal_en) |-> ($past(cal_done) || $past(start))); // R5
    AST_PLLEN_AFTER_CAL: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_en) |-> (!cal_en && !$past(cal_done))); // R5
    AST_RCAL_AFTER_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(rcal_en) |-> ($past(lock_det) && rcal_clk_en)); // R6
    AST_RCALCLK_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(rcal_clk_en) |-> (!rcal_en && (!$past(rcal_done) || $past(start)))); // R7
    AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (rst)
        ($fell(cal_ovrd) || $fell(rcal_ovrd)) |-> (!pwr_ovrd && (!cal_ovrd || !$fell(rcal_ovrd)))); // R8
    AST_HWSEQ_LAST: assert property (@(posedge clk) disable iff (rst)
        $rose(hw_seq_en) |-> (seq_done && !pwr_ovrd && !cal_ovrd && !rcal_ovrd && lockdet_use)); // R8
    AST_ERR_CODE_VALID: assert property (@(posedge clk) disable iff (rst)
        seq_err |-> (seq_err_code >= 3'd1 && seq_err_code <= 3'd5 && !seq_done)); // R9
    AST_FROZEN_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        ((seq_done || seq_err) && !start) |=> $stable(watch)); // R10
endmodule

bind pll_bringup_seq pll_bringup_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .cal_done     (cal_done),
    .lock_det     (lock_det),
    .rcal_done    (rcal_done),
    .refclk_sel   (refclk_sel),
    .refbuf_en    (refbuf_en),
    .pwr_ovrd     (pwr_ovrd),
    .cal_ovrd     (cal_ovrd),
    .rcal_ovrd    (rcal_ovrd),
    .iddq         (iddq),
    .sleep_lvl    (sleep_lvl),
    .cal_en       (cal_en),
    .pll_en       (pll_en),
    .rcal_clk_en  (rcal_clk_en),
    .rcal_en      (rcal_en),
    .lockdet_use  (lockdet_use),
    .hw_seq_en    (hw_seq_en),
    .seq_done     (seq_done),
    .seq_err      (seq_err),
    .seq_err_code (seq_err_code)
);

// File: tb/pll_bringup_seq_bench.sv
`timescale 1ns/1ps
module pll_bringup_seq_bench;
    localparam int TMO = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic cal_done = 1'b0, lock_det = 1'b0, rcal_done = 1'b0;
    logic [23:0] cal_trim;
    logic [7:0]  dco_trim, fb_ndiv;
    logic [1:0]  txref_sel, fb_mdiv, sleep_lvl;
    logic [3:0]  refclk_sel;
    logic txref_en, refbuf_en, pwr_ovrd, cal_ovrd, rcal_ovrd, iddq, cal_en, pll_en;
    logic rcal_clk_en, rcal_en, rst_sw_ctrl, clk_sw_ctrl, lockdet_use, idle_iddq_ctrl;
    logic hw_seq_en, seq_done, seq_err;
    logic [2:0]  seq_err_code;

    always #5 clk = ~clk;

    pll_bringup_seq #(.CLK_HZ(100_000), .TIMEOUT_MS(1)) u_pll_bringup_seq (
        .clk(clk), .rst(rst), .start(start), .cal_done(cal_done), .lock_det(lock_det),
        .rcal_done(rcal_done), .cal_trim(cal_trim), .dco_trim(dco_trim),
        .txref_sel(txref_sel), .txref_en(txref_en), .refclk_sel(refclk_sel),
        .refbuf_en(refbuf_en), .fb_ndiv(fb_ndiv), .fb_mdiv(fb_mdiv),
        .pwr_ovrd(pwr_ovrd), .cal_ovrd(cal_ovrd), .rcal_ovrd(rcal_ovrd), .iddq(iddq),
        .sleep_lvl(sleep_lvl), .cal_en(cal_en), .pll_en(pll_en),
        .rcal_clk_en(rcal_clk_en), .rcal_en(rcal_en), .rst_sw_ctrl(rst_sw_ctrl),
        .clk_sw_ctrl(clk_sw_ctrl), .lockdet_use(lockdet_use),
        .idle_iddq_ctrl(idle_iddq_ctrl), .hw_seq_en(hw_seq_en), .seq_done(seq_done),
        .seq_err(seq_err), .seq_err_code(seq_err_code)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // PLL responder: fault 1 cal never sets, 2 cal never clears, 3 no lock,
    // 4 rcal never sets, 5 rcal never clears
    int cal_lat = 3, lock_lat = 5, rcal_lat = 3, fault = 0;
    int cal_c = 0, lock_c = 0, rcal_c = 0;

    always @(negedge clk) begin
        if (cal_done != cal_en) begin
            if (!((cal_en && fault == 1) || (!cal_en && fault == 2))) begin
                if (cal_c >= cal_lat) begin cal_done <= cal_en; cal_c <= 0; end
                else cal_c <= cal_c + 1;
            end
        end else cal_c <= 0;
        if (!pll_en) begin lock_det <= 1'b0; lock_c <= 0; end
        else if (!lock_det && fault != 3) begin
            if (lock_c >= lock_lat) lock_det <= 1'b1;
            else lock_c <= lock_c + 1;
        end
        if (rcal_done != rcal_en) begin
            if (!((rcal_en && fault == 4) || (!rcal_en && fault == 5))) begin
                if (rcal_c >= rcal_lat) begin rcal_done <= rcal_en; rcal_c <= 0; end
                else rcal_c <= rcal_c + 1;
            end
        end else rcal_c <= 0;
    end

    // event monitor and scoreboard
    typedef struct { bit err; logic [2:0] code; } exp_t;
    exp_t exp_q[$];

    int t_iddq, t_sleep, t_refbuf, t_calen, t_callo, t_pllen, t_lock, t_rcalen;
    int t_rcallo, t_rclkoff, t_relpwr, t_relcal, t_relrcal, t_hwseq, t_done, t_err;
    logic [2:0] ovrd_at_iddq;
    logic p_iddq = 1, p_refbuf = 0, p_calen = 0, p_cald = 0, p_pllen = 0, p_lock = 0;
    logic p_rcalen = 0, p_rcald = 0, p_rclk = 0, p_pwr = 0, p_cal = 0, p_rcal = 0;
    logic p_hw = 0, p_done = 0, p_err = 0;
    logic [1:0] p_sleep = 2'b11;

    always @(negedge clk) begin
        if (!rst) begin
            if (p_iddq && !iddq) begin t_iddq = cyc; ovrd_at_iddq = {pwr_ovrd, cal_ovrd, rcal_ovrd}; end
            if (p_sleep != 2'b00 && sleep_lvl == 2'b00) t_sleep = cyc;
            if (!p_refbuf && refbuf_en) t_refbuf = cyc;
            if (!p_calen && cal_en) t_calen = cyc;
            if (p_cald && !cal_done) t_callo = cyc;
            if (!p_pllen && pll_en) t_pllen = cyc;
            if (!p_lock && lock_det) t_lock = cyc;
            if (!p_rcalen && rcal_en) t_rcalen = cyc;
            if (p_rcald && !rcal_done) t_rcallo = cyc;
            if (p_rclk && !rcal_clk_en) t_rclkoff = cyc;
            if (p_pwr && !pwr_ovrd) t_relpwr = cyc;
            if (p_cal && !cal_ovrd) t_relcal = cyc;
            if (p_rcal && !rcal_ovrd) t_relrcal = cyc;
            if (!p_hw && hw_seq_en) t_hwseq = cyc;
            if (!p_err && seq_err) t_err = cyc;
            if ((!p_done && seq_done) || (!p_err && seq_err)) begin
                if (!p_done && seq_done) t_done = cyc;
                if (exp_q.size() == 0) begin
                    check("R9", "unexpected end", 32'd1, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check("R9", "err flag", {31'd0, seq_err}, {31'd0, e.err});
                    check("R9", "err code", {29'd0, seq_err_code}, {29'd0, e.code});
                    if (!e.err) begin
                        check("R3", "fields",
                              {cal_trim, dco_trim}, {24'h000136, 8'h2A});
                        check("R3", "dividers/selects",
                              {8'd0, fb_ndiv, 6'd0, fb_mdiv, 2'd0, txref_sel, txref_en, refclk_sel, 1'b0},
                              {8'd0, 8'd25, 6'd0, 2'd0, 2'd0, 2'd2, 1'b1, 4'd0, 1'b0});
                        check("R8", "handoff ctrls",
                              {28'd0, rst_sw_ctrl, clk_sw_ctrl, lockdet_use, idle_iddq_ctrl},
                              {28'd0, 4'b0011});
                    end
                end
            end
        end
        p_iddq = iddq; p_sleep = sleep_lvl; p_refbuf = refbuf_en; p_calen = cal_en;
        p_cald = cal_done; p_pllen = pll_en; p_lock = lock_det; p_rcalen = rcal_en;
        p_rcald = rcal_done; p_rclk = rcal_clk_en; p_pwr = pwr_ovrd; p_cal = cal_ovrd;
        p_rcal = rcal_ovrd; p_hw = hw_seq_en; p_done = seq_done; p_err = seq_err;
    end

    task automatic run_case(input int cl, input int ll, input int rl, input int f,
                            input bit e_err, input logic [2:0] e_code, input bit mid,
                            output int dur);
        int t0;
        int guard;
        @(negedge clk);
        cal_lat = cl; lock_lat = ll; rcal_lat = rl; fault = f;
        repeat (8) @(negedge clk);
        exp_q.push_back('{e_err, e_code});
        start = 1'b1;
        t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        check("R12", "restart clears flags", {30'd0, seq_done, seq_err}, 32'd0);
        check("R12", "restart restores defaults",
              {24'd0, pwr_ovrd, hw_seq_en, pll_en, cal_en, iddq, rst_sw_ctrl, fb_mdiv},
              {24'd0, 6'b000011, 2'd1});
        @(negedge clk);
        check("R2", "overrides rise after start",
              {29'd0, pwr_ovrd, cal_ovrd, rcal_ovrd}, {29'd0, 3'b111});
        if (mid) begin
            repeat (18) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!(seq_done || seq_err) && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        dur = cyc - t0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int d_a, d_b, d_x;
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "reset fields",
              {cal_trim, dco_trim}, 32'd0);
        check("R1", "reset selects",
              {16'd0, txref_sel, txref_en, refclk_sel, refbuf_en, fb_mdiv, 6'd0},
              {16'd0, 2'd0, 1'b0, 4'h5, 1'b0, 2'd1, 6'd0});
        check("R1", "reset ctrls",
              {12'd0, fb_ndiv, pwr_ovrd, cal_ovrd, rcal_ovrd, iddq, sleep_lvl,
               cal_en, pll_en, rcal_clk_en, rcal_en},
              {12'd0, 8'd0, 3'b000, 1'b1, 2'b11, 4'b0000});
        check("R1", "reset handoff/status",
              {24'd0, rst_sw_ctrl, clk_sw_ctrl, lockdet_use, idle_iddq_ctrl, hw_seq_en,
               seq_done, seq_err, (seq_err_code != 0)},
              {24'd0, 8'b11000000});

        run_case(3, 5, 3, 0, 1'b0, 3'd0, 1'b0, d_a);
        check("R2", "overrides high at iddq clear", {29'd0, ovrd_at_iddq}, {29'd0, 3'b111});
        check("R4", "sleep after iddq", t_sleep - t_iddq, 1);
        check("R4", "refbuf after sleep", t_refbuf - t_sleep, 1);
        check("R4", "cal_en after refbuf", t_calen - t_refbuf, 1);
        check("R5", "pll_en after cal clear", {31'd0, t_pllen > t_callo}, 1);
        check("R6", "rcal after lock", {31'd0, t_rcalen > t_lock}, 1);
        check("R7", "rcal clk off after done clear", {31'd0, t_rclkoff > t_rcallo}, 1);
        check("R8", "cal ovrd after pwr", t_relcal - t_relpwr, 1);
        check("R8", "rcal ovrd after cal", t_relrcal - t_relcal, 1);
        check("R8", "hw seq after release", t_hwseq - t_relrcal, 1);
        check("R8", "hw seq with done", t_hwseq, t_done);
        repeat (10) @(negedge clk);
        check("R12", "done is a level", {30'd0, seq_done, hw_seq_en}, 32'd3);

        run_case(3, 5, 3, 0, 1'b0, 3'd0, 1'b1, d_b);
        check("R11", "mid-run start ignored, duration", d_b, d_a);

        run_case(2, 9, 4, 0, 1'b0, 3'd0, 1'b0, d_x);

        run_case(3, 5, 3, 1, 1'b1, 3'd1, 1'b0, d_x);
        check("R9", "cal-set timeout length", t_err - t_calen, TMO);
        run_case(3, 5, 3, 2, 1'b1, 3'd2, 1'b0, d_x);
        run_case(3, 5, 3, 3, 1'b1, 3'd3, 1'b0, d_x);
        check("R9", "lock timeout length", t_err - t_pllen, TMO);
        run_case(3, 5, 3, 4, 1'b1, 3'd4, 1'b0, d_x);
        run_case(3, 5, 3, 5, 1'b1, 3'd5, 1'b0, d_x);
        snap = {12'd0, pwr_ovrd, cal_ovrd, rcal_ovrd, iddq, sleep_lvl, cal_en, pll_en,
                rcal_clk_en, rcal_en, hw_seq_en, seq_err, seq_err_code, refclk_sel};
        repeat (20) @(negedge clk);
        check("R10", "outputs frozen after error",
              {12'd0, pwr_ovrd, cal_ovrd, rcal_ovrd, iddq, sleep_lvl, cal_en, pll_en,
               rcal_clk_en, rcal_en, hw_seq_en, seq_err, seq_err_code, refclk_sel}, snap);

        run_case(3, 5, 3, 0, 1'b0, 3'd0, 1'b0, d_x);
        check("R12", "recovery run duration", d_x, d_a);
        check("R9", "scoreboard drained", exp_q.size(), 0);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        summary();
    end
endmodule